// File: doc/BRIEF.md
# Vector Coprocessor Macro-Instruction Dispatcher

This block sits between a host CPU pipeline and a vector coprocessor. It accepts one 32-bit coprocessor instruction at a time over a valid/ready handshake. Each instruction goes into exactly one class, and the block performs that class's action.

The classes are:
- **Register moves.** A 128-bit vector register or a 32-bit control register moves to or from the host register file.
- **Divide-wait.** The block holds until the coprocessor's divide unit goes quiet.
- **Calls.** Two microprogram calls start the coprocessor at an address.
- **Arithmetic.** Every arithmetic instruction is wrapped into an upper/lower microinstruction pair and issued. The pair is then waited on until the coprocessor is idle again, so nothing overlaps.

The host sees every stall as `ins_ready` held low. Results for the host come back on a one-cycle write-back strobe. Encodings that match no class raise a one-cycle reserved-instruction strobe.

Top module: `cop2_dispatch`

## Requirements
- R1: `ins_ready` is high only while the block is idle. It is high after reset. An instruction is taken on a cycle with `ins_valid` and `ins_ready` both high, and `ins_ready` is low from the next cycle until that instruction has completed.
- R2: Format (bits 25..21) 0x01 reads vector register id (bits 15..11) through the access port, with `acc_kind` 1. In the same cycle it returns a write-back to host register rt (bits 20..16). Vector lane 0 (`acc_rdata[31:0]`) lands in `wb_data[127:96]`, and lane 3 lands in `wb_data[31:0]`.
- R3: Format 0x02 with bits 10..1 zero reads control register id, with `acc_kind` 0. It returns the 32-bit value sign-extended into `wb_data[63:0]`, with `wb_data[127:64]` zero.
- R4: Format 0x05 writes vector register id, with `acc_kind` 1 and lane k set to host word 3-k. Format 0x06 with bits 10..1 zero writes control register id, with `acc_kind` 0 and the host value in `acc_wdata[31:0]`. When the interlock bit (bit 0) is clear, either write happens in the cycle after acceptance, even while `cop_busy` is high.
- R5: A register write with the interlock bit set, accepted while `cop_busy` is high, stalls with no access until `cop_ilock_rel` is high. The write then happens in that same cycle.
- R6: An instruction whose bits 10..0 equal 0x3BF waits until `cop_q_busy` is low and does nothing else. It takes priority over the lower class, so it never issues a pair.
- R7: Function (bits 5..0) 0x38 waits until `cop_busy` is low. It then writes the 15-bit immediate from bits 20..6, zero-extended, into the start-address register (`acc_kind` 2, `acc_idx` 0).
- R8: Function 0x39 waits until `cop_busy` is low. It then reads control register `CALL_ADDR_REG` (default 27) and, in the next cycle, writes that value to the start-address register.
- R9: The upper class covers function < 0x30, and function >= 0x3C with sub-function (bits 10..6) < 0x0C. It issues upper word 0x40000000 | bits 24..0 and lower word 0x8000033C.
- R10: The lower class covers function 0x30..0x35, and function >= 0x3C with sub-function >= 0x0C. It issues upper word 0x400002FF and lower word 0x10000000 | bits 24..0.
- R11: A pair is issued as a one-cycle `issue_valid` pulse, and only when `cop_busy` is low. The host then stays stalled until `cop_busy` reads low again.
- R12: Any other encoding pulses `exc_resv` for one cycle, makes no access, issues nothing and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_word | input | 32 | Coprocessor instruction |
| ins_gpr | input | 128 | Host source register value (rt) |
| ins_ready | output | 1 | Block idle and able to take an instruction |
| wb_valid | output | 1 | Host register write-back strobe |
| wb_rt | output | 5 | Host destination register |
| wb_data | output | 128 | Write-back data |
| exc_resv | output | 1 | Reserved-instruction exception strobe |
| cop_busy | input | 1 | Coprocessor executing |
| cop_q_busy | input | 1 | Divide unit executing |
| cop_ilock_rel | input | 1 | Microprogram interlock released |
| issue_valid | output | 1 | Microinstruction pair strobe |
| issue_upper | output | 32 | Upper microinstruction |
| issue_lower | output | 32 | Lower microinstruction |
| acc_valid | output | 1 | Register access strobe |
| acc_write | output | 1 | 1 = write, 0 = read |
| acc_kind | output | 2 | 0 control, 1 vector, 2 start address |
| acc_idx | output | 5 | Register index |
| acc_wdata | output | 128 | Write data (lane k at bits 32k+31..32k) |
| acc_rdata | input | 128 | Read data, same cycle |

## Verification
The bench goes after these corner cases:

- **Lane order of the 128-bit moves.** A swapped order would show up as a mirrored quadword on write-back or on the access port.
- **Sign extension of a negative control word.** A design that zero-extends would return the wrong upper half.
- **The divide-wait encoding.** It also matches the lower-class pattern. A design with the wrong priority would issue a pair instead of stalling on the divide unit.
- **Interlock gating.** Both a write that must stall until release and a write that must not stall are checked. A design that stalls always, or never, would show a wrong stall length or an access in the wrong cycle.
- **Completion wait after an issued pair.** It is checked by measuring exactly how many cycles `ins_ready` stays low. A design that returned early would shorten that count.
- **Calls and issues while busy.** A design that ignored `cop_busy` would produce an access or issue before the expected one is queued.

// File: rtl/cop2_dispatch.sv
module cop2_dispatch #(
  parameter int CALL_ADDR_REG = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins_valid,
  input  logic [31:0]  ins_word,
  input  logic [127:0] ins_gpr,
  output logic         ins_ready,
  output logic         wb_valid,
  output logic [4:0]   wb_rt,
  output logic [127:0] wb_data,
  output logic         exc_resv,
  input  logic         cop_busy,
  input  logic         cop_q_busy,
  input  logic         cop_ilock_rel,
  output logic         issue_valid,
  output logic [31:0]  issue_upper,
  output logic [31:0]  issue_lower,
  output logic         acc_valid,
  output logic         acc_write,
  output logic [1:0]   acc_kind,
  output logic [4:0]   acc_idx,
  output logic [127:0] acc_wdata,
  input  logic [127:0] acc_rdata
);
  localparam logic [4:0]  CAR      = 5'(CALL_ADDR_REG);
  localparam logic [31:0] UP_NOP   = 32'h400002FF;
  localparam logic [31:0] LO_NOP   = 32'h8000033C;
  localparam logic [1:0]  K_CTRL   = 2'd0;
  localparam logic [1:0]  K_VEC    = 2'd1;
  localparam logic [1:0]  K_START  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_REL, S_QW, S_IW, S_CALLW, S_DONE
  } st_t;

  st_t          st, st_n;
  logic [25:0]  ir;
  logic [127:0] gpr;
  logic [31:0]  call_addr;

  logic [4:0] fmt, sub;
  logic [5:0] fn;
  assign fmt = ir[25:21];
  assign sub = ir[10:6];
  assign fn  = ir[5:0];

  logic c_vrd, c_crd, c_vwr, c_cwr, is_rd, is_wr, is_mv;
  logic c_wait, c_call0, c_call1, c_up, c_lo, c_pair, c_bad, need_idle;
  assign c_vrd  = fmt == 5'h01;
  assign c_crd  = fmt == 5'h02 && ir[10:1] == 10'd0;
  assign c_vwr  = fmt == 5'h05;
  assign c_cwr  = fmt == 5'h06 && ir[10:1] == 10'd0;
  assign is_rd  = c_vrd | c_crd;
  assign is_wr  = c_vwr | c_cwr;
  assign is_mv  = is_rd | is_wr;
  assign c_wait  = !is_mv && ir[10:0] == 11'h3BF;
  assign c_call0 = !is_mv && !c_wait && fn == 6'h38;
  assign c_call1 = !is_mv && !c_wait && fn == 6'h39;
  assign c_up    = !is_mv && !c_wait &&
                   (fn < 6'h30 || (fn >= 6'h3C && sub < 5'h0C));
  assign c_lo    = !is_mv && !c_wait && !c_up &&
                   ((fn >= 6'h30 && fn <= 6'h35) || (fn >= 6'h3C && sub >= 5'h0C));
  assign c_pair    = c_up | c_lo;
  assign need_idle = c_call0 | c_call1 | c_pair;
  assign c_bad     = !is_mv && !c_wait && !need_idle;

  logic go_exec, rd_go, wr_go, call0_go, call1_rd, callw;
  assign go_exec  = need_idle && (st == S_DEC || st == S_IW) && !cop_busy;
  assign rd_go    = st == S_DEC && is_rd;
  assign wr_go    = is_wr && ((st == S_DEC && !(cop_busy && ir[0])) ||
                              (st == S_REL && cop_ilock_rel));
  assign call0_go = c_call0 && go_exec;
  assign call1_rd = c_call1 && go_exec;
  assign callw    = st == S_CALLW;

  st_t exec_dest;
  assign exec_dest = c_call1 ? S_CALLW : (c_pair ? S_DONE : S_IDLE);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (ins_valid) st_n = S_DEC;
      S_DEC: begin
        if (is_rd)           st_n = S_IDLE;
        else if (is_wr)      st_n = wr_go ? S_IDLE : S_REL;
        else if (c_wait)     st_n = cop_q_busy ? S_QW : S_IDLE;
        else if (need_idle)  st_n = cop_busy ? S_IW : exec_dest;
        else                 st_n = S_IDLE;
      end
      S_REL:   if (cop_ilock_rel) st_n = S_IDLE;
      S_QW:    if (!cop_q_busy)   st_n = S_IDLE;
      S_IW:    if (!cop_busy)     st_n = exec_dest;
      S_CALLW: st_n = S_IDLE;
      S_DONE:  if (!cop_busy)     st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ir        <= '0;
      gpr       <= '0;
      call_addr <= '0;
    end else begin
      st <= st_n;
      if (st == S_IDLE && ins_valid) begin
        ir  <= ins_word[25:0];
        gpr <= ins_gpr;
      end
      if (call1_rd) call_addr <= acc_rdata[31:0];
    end
  end

  assign ins_ready = st == S_IDLE;
  assign exc_resv  = st == S_DEC && c_bad;

  assign wb_valid = rd_go;
  assign wb_rt    = ir[20:16];
  assign wb_data  = c_vrd ?
    {acc_rdata[31:0], acc_rdata[63:32], acc_rdata[95:64], acc_rdata[127:96]} :
    {64'd0, {32{acc_rdata[31]}}, acc_rdata[31:0]};

  assign issue_valid = c_pair && go_exec;
  assign issue_upper = c_up ? (32'h40000000 | {7'd0, ir[24:0]}) : UP_NOP;
  assign issue_lower = c_up ? LO_NOP : (32'h10000000 | {7'd0, ir[24:0]});

  assign acc_valid = rd_go | wr_go | call0_go | call1_rd | callw;
  assign acc_write = wr_go | call0_go | callw;
  assign acc_kind  = (call0_go | callw) ? K_START :
                     ((c_vrd | c_vwr) && !call1_rd) ? K_VEC : K_CTRL;
  assign acc_idx   = call1_rd ? CAR : ((call0_go | callw) ? 5'd0 : ir[15:11]);

  always_comb begin
    if (callw)         acc_wdata = {96'd0, call_addr};
    else if (call0_go) acc_wdata = {113'd0, ir[20:6]};
    else if (c_vwr)    acc_wdata = {gpr[31:0], gpr[63:32], gpr[95:64], gpr[127:96]};
    else               acc_wdata = {96'd0, gpr[31:0]};
  end
endmodule

// File: rtl/cop2_dispatch_chk.sv
module cop2_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_valid,
  input logic        ins_ready,
  input logic        wb_valid,
  input logic        exc_resv,
  input logic        cop_busy,
  input logic        issue_valid,
  input logic [31:0] issue_upper,
  input logic [31:0] issue_lower,
  input logic        acc_valid,
  input logic        acc_write
);
  // R1
  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> !ins_ready);
  // R1
  a_r1_no_activity_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid || acc_valid || wb_valid || exc_resv) |-> !ins_ready);
  // R11
  a_r11_issue_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !cop_busy);
  // R11
  a_r11_issue_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);
  // R9, R10
  a_r9_r10_nop_partner: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_lower == 32'h8000033C && issue_upper[31:25] == 7'h20) ||
                    (issue_upper == 32'h400002FF && issue_lower[31:25] == 7'h08));
  // R2
  a_r2_wb_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> acc_valid && !acc_write);
  // R12
  a_r12_exc_alone: assert property (@(posedge clk) disable iff (!rst_n)
    exc_resv |-> !acc_valid && !issue_valid && !wb_valid);
endmodule

bind cop2_dispatch cop2_dispatch_chk u_chk (.*);

// File: tb/tb_cop2_dispatch.sv
module tb_cop2_dispatch;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic         ins_valid = 0;
  logic [31:0]  ins_word = '0;
  logic [127:0] ins_gpr = '0;
  logic         ins_ready, wb_valid, exc_resv, issue_valid, acc_valid, acc_write;
  logic [4:0]   wb_rt, acc_idx;
  logic [127:0] wb_data, acc_wdata, acc_rdata;
  logic [31:0]  issue_upper, issue_lower;
  logic [1:0]   acc_kind;
  logic         cop_busy, ext_busy = 0, cop_q_busy = 0, cop_ilock_rel = 0;

  int busy_cnt = 0;
  bit iss_seen = 0;
  localparam int BUSYLEN = 4;
  assign cop_busy = (busy_cnt != 0) || ext_busy;
  always @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (iss_seen) busy_cnt <= BUSYLEN;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  function automatic logic [31:0] lane(input logic [4:0] idx, input int k);
    return 32'hA0000000 | ({27'd0, idx} << 8) | 32'(k);
  endfunction
  function automatic logic [31:0] creg(input logic [4:0] idx);
    return (idx == 5'd27) ? 32'h00001234 : (32'h87654300 | {27'd0, idx});
  endfunction
  always_comb begin
    if (acc_kind == 2'd1)
      acc_rdata = {lane(acc_idx, 3), lane(acc_idx, 2), lane(acc_idx, 1), lane(acc_idx, 0)};
    else
      acc_rdata = {96'd0, creg(acc_idx)};
  end

  cop2_dispatch dut (.*);

  int checks = 0, fails = 0;
  logic [162:0] exp_q[$];
  string        tag_q[$];

  function automatic logic [162:0] mk(input logic [2:0] k, input logic [31:0] a, input logic [127:0] d);
    return {k, a, d};
  endfunction
  function automatic logic [31:0] w(input logic [4:0] fmt, input logic [4:0] rt, input logic [4:0] id,
                                    input logic [4:0] sub, input logic [5:0] fn);
    return {6'b010010, fmt, rt, id, sub, fn};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [162:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic check_ev(input logic [162:0] o);
    logic [162:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event actual=%h expected=none", o);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (o !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, o, e);
      end
    end
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      iss_seen = issue_valid;
      if (issue_valid) check_ev(mk(3'd1, issue_upper, {96'd0, issue_lower}));
      if (acc_valid && acc_write) check_ev(mk(3'd2, {25'd0, acc_kind, acc_idx}, acc_wdata));
      if (wb_valid) check_ev(mk(3'd3, {27'd0, wb_rt}, wb_data));
      if (exc_resv) check_ev(mk(3'd4, 32'd0, 128'd0));
    end
  end

  task automatic push_in(input logic [31:0] word, input logic [127:0] g);
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_word = word;
    ins_gpr = g;
    ins_valid = 1;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ins_ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [31:0] word, input logic [127:0] g, output int n);
    push_in(word, g);
    wait_ready(n);
  endtask

  task automatic stalled(input int cyc, input string tag);
    repeat (cyc) begin
      chk(ins_ready == 0, tag, {127'd0, ins_ready}, 128'd0);
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [127:0] G = 128'h11111111_22222222_33333333_44444444;

  initial begin
    int n;
    logic [31:0] iw;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ins_ready == 1 && !issue_valid && !acc_valid && !wb_valid && !exc_resv, "R1 reset",
        {123'd0, ins_ready, issue_valid, acc_valid, wb_valid, exc_resv}, 128'h10);

    // R2 vector read, lane 0 to most significant word
    expect_ev(mk(3'd3, 32'd3, {lane(5'd7, 0), lane(5'd7, 1), lane(5'd7, 2), lane(5'd7, 3)}), "R2 vec read");
    send(w(5'h01, 5'd3, 5'd7, 5'd0, 6'd0), G, n);
    chk(n == 1, "R1 read latency", 128'(n), 128'd1);

    // R3 control read, negative and positive
    expect_ev(mk(3'd3, 32'd9, {64'd0, 32'hFFFFFFFF, 32'h87654309}), "R3 ctrl read neg");
    send(w(5'h02, 5'd9, 5'd9, 5'd0, 6'd0), G, n);
    expect_ev(mk(3'd3, 32'd10, {96'd0, 32'h00001234}), "R3 ctrl read pos");
    send(w(5'h02, 5'd10, 5'd27, 5'd0, 6'd0), G, n);

    // R4 writes without interlock while busy
    ext_busy = 1;
    expect_ev(mk(3'd2, {25'd0, 2'd1, 5'd4}, {G[31:0], G[63:32], G[95:64], G[127:96]}), "R4 vec write");
    send(w(5'h05, 5'd2, 5'd4, 5'd0, 6'd0), G, n);
    chk(n == 1, "R4 no stall vec", 128'(n), 128'd1);
    expect_ev(mk(3'd2, {25'd0, 2'd0, 5'd5}, {96'd0, G[31:0]}), "R4 ctrl write");
    send(w(5'h06, 5'd2, 5'd5, 5'd0, 6'd0), G, n);
    chk(n == 1, "R4 no stall ctrl", 128'(n), 128'd1);

    // R5 interlocked write stalls until release
    push_in(w(5'h06, 5'd2, 5'd6, 5'd0, 6'd1), G);
    stalled(4, "R5 interlock stall");
    expect_ev(mk(3'd2, {25'd0, 2'd0, 5'd6}, {96'd0, G[31:0]}), "R5 write on release");
    cop_ilock_rel = 1;
    wait_ready(n);
    cop_ilock_rel = 0;
    ext_busy = 0;

    // R6 divide wait, priority over the lower class
    cop_q_busy = 1;
    push_in(w(5'h10, 5'd0, 5'd0, 5'h0E, 6'h3F), G);
    stalled(4, "R6 q wait stall");
    cop_q_busy = 0;
    wait_ready(n);
    send(w(5'h10, 5'd0, 5'd0, 5'h0E, 6'h3F), G, n);
    chk(n == 1, "R6 no stall when q idle", 128'(n), 128'd1);

    // R7 call with immediate, held while busy
    ext_busy = 1;
    iw = {6'b010010, 5'h10, 15'h1ABC, 6'h38};
    push_in(iw, G);
    stalled(4, "R7 call waits idle");
    expect_ev(mk(3'd2, {25'd0, 2'd2, 5'd0}, {113'd0, 15'h1ABC}), "R7 start write");
    ext_busy = 0;
    wait_ready(n);

    // R8 call from control register 27
    expect_ev(mk(3'd2, {25'd0, 2'd2, 5'd0}, {96'd0, 32'h00001234}), "R8 start from ctrl");
    send(w(5'h10, 5'd0, 5'd0, 5'd0, 6'h39), G, n);
    chk(n == 2, "R8 latency", 128'(n), 128'd2);

    // R9 upper class, R11 completion wait
    iw = w(5'h10, 5'd1, 5'd2, 5'd3, 6'h28);
    expect_ev(mk(3'd1, 32'h40000000 | {7'd0, iw[24:0]}, {96'd0, 32'h8000033C}), "R9 upper lt30");
    send(iw, G, n);
    chk(n == 6, "R11 held until done", 128'(n), 128'd6);
    iw = w(5'h10, 5'd4, 5'd5, 5'h05, 6'h3D);
    expect_ev(mk(3'd1, 32'h40000000 | {7'd0, iw[24:0]}, {96'd0, 32'h8000033C}), "R9 upper sub");
    send(iw, G, n);

    // R10 lower class
    iw = w(5'h10, 5'd6, 5'd7, 5'd0, 6'h32);
    expect_ev(mk(3'd1, 32'h400002FF, {96'd0, 32'h10000000 | {7'd0, iw[24:0]}}), "R10 lower 30-35");
    send(iw, G, n);
    iw = w(5'h10, 5'd8, 5'd9, 5'h0D, 6'h3E);
    expect_ev(mk(3'd1, 32'h400002FF, {96'd0, 32'h10000000 | {7'd0, iw[24:0]}}), "R10 lower sub");
    send(iw, G, n);

    // R11 no issue while busy
    ext_busy = 1;
    iw = w(5'h10, 5'd1, 5'd1, 5'd1, 6'h05);
    push_in(iw, G);
    stalled(3, "R11 waits before issue");
    expect_ev(mk(3'd1, 32'h40000000 | {7'd0, iw[24:0]}, {96'd0, 32'h8000033C}), "R11 issue after idle");
    ext_busy = 0;
    wait_ready(n);

    // R12 reserved encodings
    expect_ev(mk(3'd4, 32'd0, 128'd0), "R12 func 36");
    send(w(5'h10, 5'd0, 5'd0, 5'd0, 6'h36), G, n);
    chk(n == 1, "R12 latency", 128'(n), 128'd1);
    expect_ev(mk(3'd4, 32'd0, 128'd0), "R12 func 3B");
    send(w(5'h06, 5'd0, 5'd0, 5'd1, 6'h3B), G, n);

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected events seen", 128'(exp_q.size()), 128'd0);
    finish_run();
  end
endmodule